// File: doc/BRIEF.md
# Byte-Serial Block Cipher Data Port Sequencer

This block sits between a byte-wide register interface and a 128-bit block-cipher core. Software, or any byte-wide master, writes three byte streams through three write ports: the block data, optional XOR data and the key. For each of the sixteen byte positions the writes come in a fixed order: the data byte, then an optional XOR byte, then the key byte. When the configured key is longer than 128 bits, the extra key bytes follow the sixteen positions. The sequencer packs all of these into the block and key registers, most-significant byte first. It then issues a single-cycle start pulse to the core and holds a busy flag until the core reports done.

After completion the sixteen result bytes are read back one at a time through a read port. Before any read, an XOR byte may be written, and it modifies only that next returned byte. A configuration byte selects encryption or decryption and the key length. While encryption is selected, a second read port returns the decryption key that the core derived during the run. A write that breaks the expected order is dropped and sets a sticky error flag. A soft clear input restarts the sequence.

Top module: `cipher_port_seq`

## Requirements
- R1: A write to the configuration byte sets the mode and the key length. Bit 5 set selects encryption and clear selects decryption, and it drives `core_encrypt`. Bits [1:0] give the key length and drive `core_key_len`: 00 = 128 bits, 01 = 192 bits, 10 = 256 bits, and 11 behaves as 128 bits.
- R2: Input writes are accepted in the order data byte, optional XOR byte, key byte, for positions 0..15. Position p lands in `core_block[127-8p -: 8]` and `core_key[255-8p -: 8]`.
- R3: When an XOR byte is written at a position, the block byte is the data byte XOR the XOR byte. Otherwise it is the data byte alone.
- R4: After position 15, a 192-bit key takes 8 more key bytes and a 256-bit key takes 16. Extra byte e lands in `core_key[127-8e -: 8]`. `core_start` is a one-cycle pulse that is raised only in the cycle after the last key byte for the selected length, and never while busy.
- R5: A write that is out of order, or that arrives together with a write on another input port, is ignored and sets `seq_err` from the next cycle. `seq_err` stays set until a reset or soft clear.
- R6: `soft_clr` returns the position and extra-key counters to their start, clears `seq_err` and `busy`, and abandons any result read-out.
- R7: `busy` is high from the cycle after `core_start` until the cycle after `core_done`. While busy, `yout_byte` reads 0 and a read does not advance the result pointer.
- R8: After done, `yout_byte` shows the result bytes most-significant first, and each `yout_rd` advances to the next byte. After the sixteenth read, `yout_byte` returns to 0 and the input sequence restarts at position 0.
- R9: An XOR-port write during read-out is XORed into the next returned result byte only.
- R10: While encryption is selected, `kout_byte` shows the captured derived key, most-significant byte first, and `kout_rd` advances it. While decryption is selected, `kout_byte` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_clr | input | 1 | Restart the sequence and clear the error flag |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration byte (bit 5 mode, bits 1:0 key length) |
| din_wr | input | 1 | Data byte write strobe |
| din_byte | input | 8 | Data byte |
| xin_wr | input | 1 | XOR byte write strobe |
| xin_byte | input | 8 | XOR byte |
| kin_wr | input | 1 | Key byte write strobe |
| kin_byte | input | 8 | Key byte |
| yout_rd | input | 1 | Result read strobe |
| yout_byte | output | 8 | Current result byte |
| kout_rd | input | 1 | Derived-key read strobe |
| kout_byte | output | 8 | Current derived-key byte |
| busy | output | 1 | Core operation in progress |
| seq_err | output | 1 | Sticky out-of-order write flag |
| core_start | output | 1 | Start pulse to the core |
| core_encrypt | output | 1 | Mode to the core |
| core_key_len | output | 2 | Key length code to the core |
| core_block | output | 8*BLK_BYTES | Assembled input block |
| core_key | output | 8*(BLK_BYTES+EXT_MAX_BYTES) | Assembled key |
| core_done | input | 1 | Core completion pulse |
| core_result | input | 8*BLK_BYTES | Core output block |
| core_dkey | input | 8*(BLK_BYTES+EXT_MAX_BYTES) | Derived key from the core |

## Verification
The bench builds the block with its default parameters: a 16-byte block and 16 extra key bytes. With these values every key-length code can be reached, including the 256-bit case in which the extra-byte counter runs its full range and the reserved code that falls back to 128 bits. A core model with adjustable latency opens a wide busy window, so reads can be tried while busy. Partial sequences, simultaneous writes and soft clears mid-sequence are checked against the captured block and key that the core receives.

// File: rtl/cps_pkg.sv
package cps_pkg;

    typedef enum logic [2:0] {
        ST_DATA,
        ST_MID,
        ST_KEY,
        ST_EXT,
        ST_WAIT
    } in_state_e;

    typedef enum logic [1:0] {
        KL_128 = 2'b00,
        KL_192 = 2'b01,
        KL_256 = 2'b10,
        KL_RSV = 2'b11
    } key_len_e;

    typedef struct packed {
        logic       wr;
        logic [7:0] data;
    } wr_port_t;

    typedef struct packed {
        logic     enc;
        key_len_e klen;
    } cfg_t;

    localparam int CFG_ENC_BIT = 5;

    // number of key bytes that follow the per-position sequence
    function automatic int ext_bytes(key_len_e kl, int ext_max);
        case (kl)
            KL_192:  return ext_max / 2;
            KL_256:  return ext_max;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/cps_in_seq.sv
module cps_in_seq
    import cps_pkg::*;
#(
    parameter int BLK_BYTES = 16,
    parameter int EXT_MAX   = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             soft_clr,
    input  wr_port_t                         din,
    input  wr_port_t                         xin,
    input  wr_port_t                         kin,
    input  key_len_e                         klen,
    input  logic                             res_active,
    input  logic                             blk_done,
    output logic [BLK_BYTES*8-1:0]           block_o,
    output logic [(BLK_BYTES+EXT_MAX)*8-1:0] key_o,
    output logic                             start_o,
    output logic                             err_o
);
    localparam int KEY_BYTES = BLK_BYTES + EXT_MAX;
    localparam int POS_W     = $clog2(BLK_BYTES);
    localparam int EXT_W     = $clog2(EXT_MAX);
    localparam int BW        = $clog2(BLK_BYTES * 8);
    localparam int KW        = $clog2(KEY_BYTES * 8);

    in_state_e              state_q;
    logic [POS_W-1:0]       pos_q;
    logic [EXT_W-1:0]       ecnt_q;
    logic [BLK_BYTES*8-1:0] block_q;
    logic [KEY_BYTES*8-1:0] key_q;
    logic                   start_q;

    logic             any_wr, multi_wr, ok_wr;
    logic [BW-1:0]    boff;
    logic [KW-1:0]    koff, eoff;
    logic             pos_last, ext_last, ext_none;
    int               ext_need;

    always_comb begin
        any_wr   = din.wr | xin.wr | kin.wr;
        multi_wr = (din.wr & xin.wr) | (din.wr & kin.wr) | (xin.wr & kin.wr);
        case (state_q)
            ST_DATA: ok_wr = din.wr;
            ST_MID:  ok_wr = xin.wr | kin.wr;
            ST_KEY:  ok_wr = kin.wr;
            ST_EXT:  ok_wr = kin.wr;
            ST_WAIT: ok_wr = xin.wr & res_active;
            default: ok_wr = 1'b0;
        endcase
        err_o    = any_wr & (multi_wr | ~ok_wr);
        ext_need = ext_bytes(klen, EXT_MAX);
        ext_none = (ext_need == 0);
        pos_last = (pos_q == POS_W'(BLK_BYTES - 1));
        ext_last = ext_none || (ecnt_q == EXT_W'(ext_need - 1));
        boff     = BW'((BLK_BYTES - 1 - int'(pos_q)) * 8);
        koff     = KW'((KEY_BYTES - 1 - int'(pos_q)) * 8);
        eoff     = KW'((EXT_MAX - 1 - int'(ecnt_q)) * 8);
    end

    always_ff @(posedge clk) begin
        start_q <= 1'b0;
        if (rst) begin
            state_q <= ST_DATA;
            pos_q   <= '0;
            ecnt_q  <= '0;
            block_q <= '0;
            key_q   <= '0;
        end else if (soft_clr) begin
            state_q <= ST_DATA;
            pos_q   <= '0;
            ecnt_q  <= '0;
        end else if (state_q == ST_WAIT) begin
            if (blk_done) begin
                state_q <= ST_DATA;
                pos_q   <= '0;
            end
        end else if (any_wr && !err_o) begin
            case (state_q)
                ST_DATA: begin
                    block_q[boff +: 8] <= din.data;
                    state_q            <= ST_MID;
                end
                ST_MID: begin
                    if (xin.wr) begin
                        block_q[boff +: 8] <= block_q[boff +: 8] ^ xin.data;
                        state_q            <= ST_KEY;
                    end
                end
                ST_EXT: begin
                    key_q[eoff +: 8] <= kin.data;
                    if (ext_last) begin
                        state_q <= ST_WAIT;
                        start_q <= 1'b1;
                    end else begin
                        ecnt_q <= ecnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
            // key byte closing a position
            if ((state_q == ST_MID || state_q == ST_KEY) && kin.wr) begin
                key_q[koff +: 8] <= kin.data;
                if (!pos_last) begin
                    pos_q   <= pos_q + 1'b1;
                    state_q <= ST_DATA;
                end else if (ext_none) begin
                    state_q <= ST_WAIT;
                    start_q <= 1'b1;
                end else begin
                    state_q <= ST_EXT;
                    ecnt_q  <= '0;
                end
            end
        end
    end

    assign block_o = block_q;
    assign key_o   = key_q;
    assign start_o = start_q;

endmodule

// File: rtl/cps_res_port.sv
module cps_res_port
    import cps_pkg::*;
#(
    parameter int BLK_BYTES = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   soft_clr,
    input  logic                   done_cap,
    input  logic [BLK_BYTES*8-1:0] result_i,
    input  logic                   rd,
    input  wr_port_t               xin,
    output logic [7:0]             byte_o,
    output logic                   active_o,
    output logic                   blk_done_o
);
    localparam int PTR_W = $clog2(BLK_BYTES);
    localparam int BW    = $clog2(BLK_BYTES * 8);

    logic [BLK_BYTES*8-1:0] res_q;
    logic [PTR_W-1:0]       ptr_q;
    logic [7:0]             pend_q;
    logic                   active_q, done_q;
    logic [BW-1:0]          roff;

    assign roff = BW'((BLK_BYTES - 1 - int'(ptr_q)) * 8);

    always_ff @(posedge clk) begin
        done_q <= 1'b0;
        if (rst) begin
            res_q    <= '0;
            ptr_q    <= '0;
            pend_q   <= '0;
            active_q <= 1'b0;
        end else if (soft_clr) begin
            ptr_q    <= '0;
            pend_q   <= '0;
            active_q <= 1'b0;
        end else if (done_cap) begin
            res_q    <= result_i;
            ptr_q    <= '0;
            pend_q   <= '0;
            active_q <= 1'b1;
        end else if (active_q) begin
            if (rd) begin
                pend_q <= xin.wr ? xin.data : 8'h00;
                ptr_q  <= ptr_q + 1'b1;
                if (ptr_q == PTR_W'(BLK_BYTES - 1)) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end
            end else if (xin.wr) begin
                pend_q <= xin.data;
            end
        end
    end

    assign byte_o     = active_q ? (res_q[roff +: 8] ^ pend_q) : 8'h00;
    assign active_o   = active_q;
    assign blk_done_o = done_q;

endmodule

// File: rtl/cps_key_port.sv
module cps_key_port #(
    parameter int KEY_BYTES = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   soft_clr,
    input  logic                   done_cap,
    input  logic [KEY_BYTES*8-1:0] dkey_i,
    input  logic                   enc,
    input  logic                   rd,
    output logic [7:0]             byte_o
);
    localparam int KP_W = $clog2(KEY_BYTES);
    localparam int KW   = $clog2(KEY_BYTES * 8);

    logic [KEY_BYTES*8-1:0] dkey_q;
    logic [KP_W-1:0]        kptr_q;
    logic [KW-1:0]          koff;

    assign koff = KW'((KEY_BYTES - 1 - int'(kptr_q)) * 8);

    always_ff @(posedge clk) begin
        if (rst) begin
            dkey_q <= '0;
            kptr_q <= '0;
        end else if (soft_clr) begin
            kptr_q <= '0;
        end else if (done_cap) begin
            dkey_q <= dkey_i;
            kptr_q <= '0;
        end else if (rd && enc) begin
            kptr_q <= (kptr_q == KP_W'(KEY_BYTES - 1)) ? '0 : kptr_q + 1'b1;
        end
    end

    assign byte_o = enc ? dkey_q[koff +: 8] : 8'h00;

endmodule

// File: rtl/cipher_port_seq.sv
module cipher_port_seq
    import cps_pkg::*;
#(
    parameter int BLK_BYTES     = 16,
    parameter int EXT_MAX_BYTES = 16
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   soft_clr,
    input  logic                                   cfg_wr,
    input  logic [7:0]                             cfg_wdata,
    input  logic                                   din_wr,
    input  logic [7:0]                             din_byte,
    input  logic                                   xin_wr,
    input  logic [7:0]                             xin_byte,
    input  logic                                   kin_wr,
    input  logic [7:0]                             kin_byte,
    input  logic                                   yout_rd,
    output logic [7:0]                             yout_byte,
    input  logic                                   kout_rd,
    output logic [7:0]                             kout_byte,
    output logic                                   busy,
    output logic                                   seq_err,
    output logic                                   core_start,
    output logic                                   core_encrypt,
    output logic [1:0]                             core_key_len,
    output logic [BLK_BYTES*8-1:0]                 core_block,
    output logic [(BLK_BYTES+EXT_MAX_BYTES)*8-1:0] core_key,
    input  logic                                   core_done,
    input  logic [BLK_BYTES*8-1:0]                 core_result,
    input  logic [(BLK_BYTES+EXT_MAX_BYTES)*8-1:0] core_dkey
);
    localparam int KEY_BYTES = BLK_BYTES + EXT_MAX_BYTES;

    cfg_t     cfg_q;
    wr_port_t din_p, xin_p, kin_p, xin_solo;
    logic     busy_q, err_q, start_w, err_w, done_cap;
    logic     res_active, blk_done;
    logic     cfg_unused;

    assign cfg_unused = ^{cfg_wdata[7:CFG_ENC_BIT+1], cfg_wdata[CFG_ENC_BIT-1:2]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{enc: 1'b0, klen: KL_128};
        end else if (cfg_wr) begin
            cfg_q <= '{enc: cfg_wdata[CFG_ENC_BIT], klen: key_len_e'(cfg_wdata[1:0])};
        end
    end

    assign din_p    = '{wr: din_wr, data: din_byte};
    assign xin_p    = '{wr: xin_wr, data: xin_byte};
    assign kin_p    = '{wr: kin_wr, data: kin_byte};
    assign xin_solo = '{wr: xin_wr & ~din_wr & ~kin_wr, data: xin_byte};
    assign done_cap = core_done & busy_q;

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            busy_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (start_w)
                busy_q <= 1'b1;
            else if (core_done)
                busy_q <= 1'b0;
            if (err_w)
                err_q <= 1'b1;
        end
    end

    cps_in_seq #(
        .BLK_BYTES (BLK_BYTES),
        .EXT_MAX   (EXT_MAX_BYTES)
    ) in_seq_i (
        .clk        (clk),
        .rst        (rst),
        .soft_clr   (soft_clr),
        .din        (din_p),
        .xin        (xin_p),
        .kin        (kin_p),
        .klen       (cfg_q.klen),
        .res_active (res_active),
        .blk_done   (blk_done),
        .block_o    (core_block),
        .key_o      (core_key),
        .start_o    (start_w),
        .err_o      (err_w)
    );

    cps_res_port #(
        .BLK_BYTES (BLK_BYTES)
    ) res_port_i (
        .clk        (clk),
        .rst        (rst),
        .soft_clr   (soft_clr),
        .done_cap   (done_cap),
        .result_i   (core_result),
        .rd         (yout_rd),
        .xin        (xin_solo),
        .byte_o     (yout_byte),
        .active_o   (res_active),
        .blk_done_o (blk_done)
    );

    cps_key_port #(
        .KEY_BYTES (KEY_BYTES)
    ) key_port_i (
        .clk      (clk),
        .rst      (rst),
        .soft_clr (soft_clr),
        .done_cap (done_cap),
        .dkey_i   (core_dkey),
        .enc      (cfg_q.enc),
        .rd       (kout_rd),
        .byte_o   (kout_byte)
    );

    assign busy         = busy_q;
    assign seq_err      = err_q | (cfg_unused & 1'b0);
    assign core_start   = start_w;
    assign core_encrypt = cfg_q.enc;
    assign core_key_len = cfg_q.klen;

endmodule

// File: rtl/cps_chk.sv
module cps_chk (
    input logic       clk,
    input logic       rst,
    input logic       soft_clr,
    input logic       din_wr,
    input logic       xin_wr,
    input logic       kin_wr,
    input logic       busy,
    input logic       seq_err,
    input logic       core_start,
    input logic       core_done,
    input logic [7:0] yout_byte
);
    assert_start_sets_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (core_start && !soft_clr) |=> busy);

    assert_done_clears_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && core_done && !core_start) |=> !busy);

    assert_busy_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (yout_byte == 8'h00));

    assert_start_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        core_start |=> !core_start);

    assert_no_start_while_busy_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> !core_start);

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (seq_err && !soft_clr) |=> seq_err);

    assert_multi_write_err_R5: assert property (@(posedge clk) disable iff (rst)
        (($countones({din_wr, xin_wr, kin_wr}) > 1) && !soft_clr) |=> seq_err);

    assert_soft_clr_R6: assert property (@(posedge clk) disable iff (rst)
        soft_clr |=> (!seq_err && !busy));
endmodule

bind cipher_port_seq cps_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .soft_clr   (soft_clr),
    .din_wr     (din_wr),
    .xin_wr     (xin_wr),
    .kin_wr     (kin_wr),
    .busy       (busy),
    .seq_err    (seq_err),
    .core_start (core_start),
    .core_done  (core_done),
    .yout_byte  (yout_byte)
);

// File: tb/cipher_port_seq_tb.sv
`timescale 1ns/100ps
module cipher_port_seq_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         soft_clr = 1'b0;
    logic         cfg_wr = 1'b0;
    logic [7:0]   cfg_wdata = 8'h00;
    logic         din_wr = 1'b0, xin_wr = 1'b0, kin_wr = 1'b0;
    logic [7:0]   din_byte = 8'h00, xin_byte = 8'h00, kin_byte = 8'h00;
    logic         yout_rd = 1'b0, kout_rd = 1'b0;
    logic [7:0]   yout_byte, kout_byte;
    logic         busy, seq_err, core_start, core_encrypt;
    logic [1:0]   core_key_len;
    logic [127:0] core_block;
    logic [255:0] core_key;
    logic         core_done = 1'b0;
    logic [127:0] core_result = '0;
    logic [255:0] core_dkey = '0;

    always #2.5 clk = ~clk;

    cipher_port_seq dut_i (
        .clk(clk), .rst(rst), .soft_clr(soft_clr),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .din_wr(din_wr), .din_byte(din_byte),
        .xin_wr(xin_wr), .xin_byte(xin_byte),
        .kin_wr(kin_wr), .kin_byte(kin_byte),
        .yout_rd(yout_rd), .yout_byte(yout_byte),
        .kout_rd(kout_rd), .kout_byte(kout_byte),
        .busy(busy), .seq_err(seq_err),
        .core_start(core_start), .core_encrypt(core_encrypt),
        .core_key_len(core_key_len), .core_block(core_block),
        .core_key(core_key), .core_done(core_done),
        .core_result(core_result), .core_dkey(core_dkey)
    );

    // core model: fixed latency, result = block ^ upper key half, derived key = ~key
    int           lat_init = 4;
    int           lat = 0;
    int           start_cnt = 0;
    logic [127:0] cap_blk = '0;
    logic [255:0] cap_key = '0;
    logic         cap_enc = 1'b0;
    logic [1:0]   cap_kl = 2'b00;

    always @(posedge clk) begin
        core_done <= 1'b0;
        if (core_start) begin
            cap_blk   <= core_block;
            cap_key   <= core_key;
            cap_enc   <= core_encrypt;
            cap_kl    <= core_key_len;
            start_cnt <= start_cnt + 1;
            lat       <= lat_init;
        end else if (lat != 0) begin
            lat <= lat - 1;
            if (lat == 1) begin
                core_done   <= 1'b1;
                core_result <= cap_blk ^ cap_key[255:128];
                core_dkey   <= ~cap_key;
            end
        end
    end

    int checks = 0;
    int fails = 0;

    task automatic chk(input logic ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int p, input logic [7:0] b);
        @(negedge clk);
        case (p)
            0: begin din_wr = 1'b1; din_byte = b; end
            1: begin xin_wr = 1'b1; xin_byte = b; end
            default: begin kin_wr = 1'b1; kin_byte = b; end
        endcase
        @(negedge clk);
        din_wr = 1'b0; xin_wr = 1'b0; kin_wr = 1'b0;
    endtask

    task automatic rd_y(output logic [7:0] b);
        @(negedge clk);
        yout_rd = 1'b1;
        #1 b = yout_byte;
        @(negedge clk);
        yout_rd = 1'b0;
    endtask

    task automatic rd_k(output logic [7:0] b);
        @(negedge clk);
        kout_rd = 1'b1;
        #1 b = kout_byte;
        @(negedge clk);
        kout_rd = 1'b0;
    endtask

    task automatic do_clr();
        @(negedge clk);
        soft_clr = 1'b1;
        @(negedge clk);
        soft_clr = 1'b0;
        chk(seq_err == 1'b0 && busy == 1'b0, "R6 soft clear", {seq_err, busy}, 0);
    endtask

    logic [255:0] kmir = '0;

    task automatic run_txn(input logic enc, input logic [1:0] kl, input logic inx,
                           input logic outx, input logic [7:0] seed,
                           input logic busy_probe, input logic err_exp);
        logic [127:0] eb;
        logic [127:0] er;
        logic [7:0]   d, x, k, b, ox;
        int           ext, s0;
        ext = (kl == 2'b01) ? 8 : (kl == 2'b10) ? 16 : 0;
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = {2'b00, enc, 3'b000, kl};
        @(negedge clk);
        cfg_wr = 1'b0;
        chk(core_encrypt == enc && core_key_len == kl, "R1 config", {core_encrypt, core_key_len}, {enc, kl});
        s0 = start_cnt;
        eb = '0;
        for (int i = 0; i < 16; i++) begin
            d = seed + 8'(i * 17);
            x = seed ^ 8'(i * 29 + 3);
            k = ~seed + 8'(i * 5);
            wr(0, d);
            if (inx) wr(1, x);
            eb[(15 - i) * 8 +: 8] = inx ? (d ^ x) : d;
            if (ext == 0 && i == 15)
                chk(start_cnt == s0, "R4 no early start", start_cnt, s0);
            wr(2, k);
            kmir[(31 - i) * 8 +: 8] = k;
        end
        for (int j = 0; j < ext; j++) begin
            k = seed ^ 8'(j * 11 + 1);
            if (j == ext - 1)
                chk(start_cnt == s0, "R4 start waits for last extra key byte", start_cnt, s0);
            wr(2, k);
            kmir[(15 - j) * 8 +: 8] = k;
        end
        repeat (3) @(negedge clk);
        if (busy_probe) begin
            rd_y(b);
            chk(busy == 1'b1 && b == 8'h00, "R7 read while busy", {busy, b}, {1'b1, 8'h00});
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(start_cnt == s0 + 1, "R4 single start", start_cnt, s0 + 1);
        chk(cap_blk == eb, "R2 R3 block assembly", cap_blk, eb);
        chk(cap_key == kmir, "R2 R4 key assembly", cap_key, kmir);
        chk(cap_enc == enc && cap_kl == kl, "R1 mode at start", {cap_enc, cap_kl}, {enc, kl});
        er = eb ^ kmir[255:128];
        for (int i = 0; i < 16; i++) begin
            ox = 8'h00;
            if (outx && (i % 3 == 0)) begin
                ox = seed ^ 8'(i + 8'h5a);
                wr(1, ox);
            end
            rd_y(b);
            chk(b == (er[(15 - i) * 8 +: 8] ^ ox), "R8 R9 result byte", b, er[(15 - i) * 8 +: 8] ^ ox);
        end
        @(negedge clk);
        chk(yout_byte == 8'h00, "R8 read-out closed", yout_byte, 0);
        if (enc) begin
            for (int j = 0; j < 3; j++) begin
                rd_k(b);
                chk(b == ~kmir[(31 - j) * 8 +: 8], "R10 derived key byte", b, ~kmir[(31 - j) * 8 +: 8]);
            end
        end else begin
            rd_k(b);
            chk(b == 8'h00, "R10 key out zero in decrypt", b, 0);
        end
        chk(seq_err == err_exp, "R5 error flag after transaction", seq_err, err_exp);
    endtask

    // {enc, klen[1:0], in_xor, out_xor, seed[7:0]}
    localparam logic [12:0] VECS [0:5] = '{
        {1'b1, 2'b00, 1'b0, 1'b0, 8'h11},
        {1'b1, 2'b01, 1'b1, 1'b0, 8'h3c},
        {1'b1, 2'b10, 1'b1, 1'b1, 8'ha5},
        {1'b0, 2'b00, 1'b0, 1'b1, 8'h72},
        {1'b0, 2'b10, 1'b0, 1'b0, 8'he9},
        {1'b1, 2'b11, 1'b1, 1'b0, 8'h06}
    };

    initial begin
        logic [7:0] b;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && seq_err == 0 && core_start == 0 && yout_byte == 0 && core_encrypt == 0,
            "R7 R5 reset state", {busy, seq_err, core_start, yout_byte}, 0);
        chk(core_block == '0 && core_key == '0 && core_key_len == 2'b00, "R1 R2 reset registers",
            core_block, 0);

        for (int v = 0; v < 6; v++)
            run_txn(VECS[v][12], VECS[v][11:10], VECS[v][9], VECS[v][8], VECS[v][7:0], 1'b0, 1'b0);

        // R5: key byte before data is dropped and flagged
        wr(2, 8'hee);
        chk(seq_err == 1'b1, "R5 out-of-order key write", seq_err, 1);
        wr(1, 8'hdd);
        chk(seq_err == 1'b1, "R5 flag stays set", seq_err, 1);
        run_txn(1'b1, 2'b00, 1'b1, 1'b0, 8'h44, 1'b0, 1'b1);
        do_clr();

        // R5: two ports in one cycle
        @(negedge clk);
        din_wr = 1'b1; din_byte = 8'h99; kin_wr = 1'b1; kin_byte = 8'h98;
        @(negedge clk);
        din_wr = 1'b0; kin_wr = 1'b0;
        chk(seq_err == 1'b1, "R5 simultaneous writes", seq_err, 1);
        run_txn(1'b0, 2'b01, 1'b0, 1'b0, 8'h5e, 1'b0, 1'b1);
        do_clr();

        // R6: partial sequence abandoned by soft clear
        wr(0, 8'h01); wr(1, 8'h02); wr(2, 8'h03); wr(0, 8'h04);
        do_clr();
        run_txn(1'b1, 2'b10, 1'b0, 1'b1, 8'h87, 1'b0, 1'b0);

        // R7: long core latency, read during busy does not advance
        lat_init = 20;
        run_txn(1'b1, 2'b00, 1'b0, 1'b0, 8'hc3, 1'b1, 1'b0);
        lat_init = 4;

        // R8: read with no result pending returns zero
        rd_y(b);
        chk(b == 8'h00, "R8 idle read", b, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule